// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block works out where an 8-bit microcontroller fetches next. Each transfer carries the current program counter, the instruction length in bytes (1 to 3), the opcode byte, up to two operand bytes, the accumulator, the data pointer, a branch-taken flag and an instruction class code. The block returns the next program counter. For table lookups it also returns a code-memory read address. The condition behind a branch, the stack traffic of calls and the fetch itself belong to neighbouring logic.

Requests arrive on a valid/ready input channel. Results leave on a valid/ready output channel through a one-entry output register. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. Its result shows on the outputs from the next edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. When the consumer holds `out_ready` low while a result is pending, the result stays frozen and no new request is taken. The code space is 16 bits wide, and every sum wraps modulo 65536.

Class codes on `in_kind` are:
- 0: sequential
- 1: relative branch
- 2: absolute 11-bit jump or call
- 3: long jump or call
- 4: table read
- 5 to 7: treated as sequential

Top module: `pcnu_next_pc`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid` is 0 and `in_ready` is 1.
- R2: For class 0, and for the unused codes 5, 6 and 7, `out_next_pc` is `in_pc + in_len` modulo 65536, whatever `in_taken` is.
- R3: For class 1 with `in_taken` = 1, `out_next_pc` is (`in_pc + in_len`) plus a sign-extended 8-bit offset, modulo 65536. The offset is `in_op2` when `in_len` is 3, and `in_op1` otherwise.
- R4: For class 1 with `in_taken` = 0, `out_next_pc` is `in_pc + in_len`.
- R5: For class 2, `out_next_pc` is built as follows, and `in_taken` has no effect:
  - bits 15:11 are bits 15:11 of `in_pc + in_len`;
  - bits 10:8 are `in_opcode[7:5]`;
  - bits 7:0 are `in_op1`.
- R6: For class 3, `out_next_pc` is `{in_op1, in_op2}`. The high byte comes first.
- R7: For class 4:
  - `out_code_rd` is 1;
  - `out_code_addr` is `in_acc` plus (`in_dptr` when `in_tbl_dptr` = 1, else `in_pc + in_len`), modulo 65536;
  - `out_next_pc` is `in_pc + in_len`.
  For every other class, `out_code_rd` is 0 and `out_code_addr` is 0.
- R8: A request is taken on an edge with `in_valid` and `in_ready` both high. `out_valid` and its result appear from that edge on. `in_ready` equals `!out_valid || out_ready`.
- R9: While `out_valid` = 1 and `out_ready` = 0, the outputs hold their values and `in_ready` is 0, so a request offered meanwhile is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_pc | input | 16 | Address of the current instruction |
| in_len | input | 2 | Instruction length in bytes, 1 to 3 |
| in_opcode | input | 8 | Opcode byte |
| in_op1 | input | 8 | First operand byte |
| in_op2 | input | 8 | Second operand byte |
| in_acc | input | 8 | Accumulator |
| in_dptr | input | 16 | Data pointer |
| in_taken | input | 1 | Branch condition outcome |
| in_kind | input | 3 | Instruction class code |
| in_tbl_dptr | input | 1 | Table base select: 1 = data pointer, 0 = following address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_next_pc | output | 16 | Next program counter |
| out_code_addr | output | 16 | Code-memory read address |
| out_code_rd | output | 1 | Code-memory read requested |

## Verification
Every result is due exactly one edge after its request is taken. The bench drives a request half a cycle before an edge, drops `in_valid` just after that edge, and reads the outputs at the following falling edge. The stall scenario first leaves a result pending with `out_ready` low and offers a second request. It checks at the next falling edge that the first result is unchanged, then releases `out_ready` and expects the second result one edge after the release.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;
  localparam int unsigned PC_W   = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ABS_W  = 11;
  localparam int unsigned LEN_W  = 2;
  localparam int unsigned KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_SEQ  = 3'd0,
    KIND_REL  = 3'd1,
    KIND_ABS  = 3'd2,
    KIND_LONG = 3'd3,
    KIND_TBL  = 3'd4
  } kind_e;
endpackage

// File: rtl/pcnu_seq_add.sv
module pcnu_seq_add #(
  parameter int unsigned ADDR_W = pcnu_pkg::PC_W,
  parameter int unsigned LEN_W  = pcnu_pkg::LEN_W
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] follow
);
  localparam int unsigned PAD_W = ADDR_W - LEN_W;

  // Address of the following instruction, wrapping in the code space.
  assign follow = pc + {{PAD_W{1'b0}}, len};
endmodule

// File: rtl/pcnu_branch_tgt.sv
module pcnu_branch_tgt #(
  parameter int unsigned ADDR_W = pcnu_pkg::PC_W,
  parameter int unsigned BYTE_W = pcnu_pkg::BYTE_W,
  parameter int unsigned ABS_W  = pcnu_pkg::ABS_W,
  parameter int unsigned LEN_W  = pcnu_pkg::LEN_W
) (
  input  logic [ADDR_W-1:0]          follow,
  input  logic [BYTE_W-1:0]          opcode,
  input  logic [BYTE_W-1:0]          op1,
  input  logic [BYTE_W-1:0]          op2,
  input  logic [LEN_W-1:0]           len,
  input  logic                       taken,
  input  logic [pcnu_pkg::KIND_W-1:0] kind,
  output logic [ADDR_W-1:0]          next_pc
);
  import pcnu_pkg::*;

  localparam int unsigned OPC_W  = ABS_W - BYTE_W;
  localparam int unsigned KEEP_W = ADDR_W - ABS_W;
  localparam int unsigned EXT_W  = ADDR_W - BYTE_W;
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(3);

  logic [BYTE_W-1:0] rel_byte;
  logic [ADDR_W-1:0] rel_ext;
  logic [ADDR_W-1:0] rel_tgt;
  logic [ABS_W-1:0]  abs_field;
  logic [ADDR_W-1:0] abs_tgt;
  logic [ADDR_W-1:0] long_tgt;

  // Offset sits in the last byte of the instruction.
  assign rel_byte = (len == LEN_MAX) ? op2 : op1;
  assign rel_ext  = {{EXT_W{rel_byte[BYTE_W-1]}}, rel_byte};
  assign rel_tgt  = follow + rel_ext;

  assign abs_field = {opcode[BYTE_W-1 -: OPC_W], op1};

  generate
    if (KEEP_W > 0) begin : g_page_keep
      assign abs_tgt = {follow[ADDR_W-1 -: KEEP_W], abs_field};
    end else begin : g_page_full
      assign abs_tgt = abs_field[ADDR_W-1:0];
    end
  endgenerate

  assign long_tgt = ADDR_W'({op1, op2});

  always_comb begin
    unique case (kind)
      KIND_REL:  next_pc = taken ? rel_tgt : follow;
      KIND_ABS:  next_pc = abs_tgt;
      KIND_LONG: next_pc = long_tgt;
      default:   next_pc = follow;
    endcase
  end
endmodule

// File: rtl/pcnu_table_addr.sv
module pcnu_table_addr #(
  parameter int unsigned ADDR_W = pcnu_pkg::PC_W,
  parameter int unsigned BYTE_W = pcnu_pkg::BYTE_W
) (
  input  logic [ADDR_W-1:0] follow,
  input  logic [ADDR_W-1:0] dptr,
  input  logic [BYTE_W-1:0] acc,
  input  logic              use_dptr,
  input  logic              enable,
  output logic [ADDR_W-1:0] code_addr,
  output logic              code_rd
);
  localparam int unsigned EXT_W = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] sum;

  assign base      = use_dptr ? dptr : follow;
  assign sum       = base + {{EXT_W{1'b0}}, acc};
  assign code_addr = enable ? sum : '0;
  assign code_rd   = enable;
endmodule

// File: rtl/pcnu_out_stage.sv
module pcnu_out_stage #(
  parameter int unsigned DATA_W = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  logic full_q;
  logic [DATA_W-1:0] data_q;

  assign up_ready = !full_q || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (up_ready) begin
      full_q <= up_valid;
      if (up_valid) data_q <= up_data;
    end
  end

  assign dn_valid = full_q;
  assign dn_data  = data_q;
endmodule

// File: rtl/pcnu_next_pc.sv
module pcnu_next_pc #(
  parameter int unsigned ADDR_W = pcnu_pkg::PC_W,
  parameter int unsigned BYTE_W = pcnu_pkg::BYTE_W,
  parameter int unsigned ABS_W  = pcnu_pkg::ABS_W,
  parameter int unsigned LEN_W  = pcnu_pkg::LEN_W,
  parameter int unsigned KIND_W = pcnu_pkg::KIND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [BYTE_W-1:0] in_opcode,
  input  logic [BYTE_W-1:0] in_op1,
  input  logic [BYTE_W-1:0] in_op2,
  input  logic [BYTE_W-1:0] in_acc,
  input  logic [ADDR_W-1:0] in_dptr,
  input  logic              in_taken,
  input  logic [KIND_W-1:0] in_kind,
  input  logic              in_tbl_dptr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_next_pc,
  output logic [ADDR_W-1:0] out_code_addr,
  output logic              out_code_rd
);
  import pcnu_pkg::*;

  localparam int unsigned RES_W = 2 * ADDR_W + 1;

  logic [ADDR_W-1:0] follow;
  logic [ADDR_W-1:0] nxt;
  logic [ADDR_W-1:0] caddr;
  logic              crd;
  logic              is_tbl;
  logic [RES_W-1:0]  res_d;
  logic [RES_W-1:0]  res_q;

  pcnu_seq_add #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .pc(in_pc), .len(in_len), .follow(follow)
  );

  pcnu_branch_tgt #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .ABS_W(ABS_W), .LEN_W(LEN_W)) u_tgt (
    .follow(follow), .opcode(in_opcode), .op1(in_op1), .op2(in_op2),
    .len(in_len), .taken(in_taken), .kind(in_kind), .next_pc(nxt)
  );

  assign is_tbl = (in_kind == KIND_TBL);

  pcnu_table_addr #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_tbl (
    .follow(follow), .dptr(in_dptr), .acc(in_acc), .use_dptr(in_tbl_dptr),
    .enable(is_tbl), .code_addr(caddr), .code_rd(crd)
  );

  assign res_d = {nxt, caddr, crd};

  pcnu_out_stage #(.DATA_W(RES_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(res_d),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(res_q)
  );

  assign out_next_pc   = res_q[RES_W-1 -: ADDR_W];
  assign out_code_addr = res_q[ADDR_W:1];
  assign out_code_rd   = res_q[0];
endmodule

// File: rtl/pcnu_next_pc_chk.sv
module pcnu_next_pc_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LEN_W  = 2,
  parameter int unsigned KIND_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_pc,
  input logic [LEN_W-1:0]  in_len,
  input logic [BYTE_W-1:0] in_op1,
  input logic [BYTE_W-1:0] in_op2,
  input logic [KIND_W-1:0] in_kind,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_next_pc,
  input logic [ADDR_W-1:0] out_code_addr,
  input logic              out_code_rd
);
  logic take;
  assign take = in_valid && in_ready;

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  assert_take_gives_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_next_pc) &&
                                   $stable(out_code_addr) && $stable(out_code_rd)));

  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_long_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_kind == 3'd3) |=> (out_next_pc == ADDR_W'({$past(in_op1), $past(in_op2)})));

  assert_no_read_outside_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_kind != 3'd4) |=> (!out_code_rd && out_code_addr == '0));

  assert_seq_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_kind == 3'd0) |=>
      (out_next_pc == ADDR_W'($past(in_pc) + ADDR_W'($past(in_len)))));
endmodule

bind pcnu_next_pc pcnu_next_pc_chk #(
  .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W), .KIND_W(KIND_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_pc(in_pc), .in_len(in_len), .in_op1(in_op1), .in_op2(in_op2),
  .in_kind(in_kind), .out_valid(out_valid), .out_ready(out_ready),
  .out_next_pc(out_next_pc), .out_code_addr(out_code_addr), .out_code_rd(out_code_rd)
);

// File: tb/pcnu_next_pc_test.sv
`timescale 1ns/1ps
module pcnu_next_pc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_pc = '0;
  logic [1:0]  in_len = 2'd1;
  logic [7:0]  in_opcode = '0, in_op1 = '0, in_op2 = '0, in_acc = '0;
  logic [15:0] in_dptr = '0;
  logic        in_taken = 1'b0;
  logic [2:0]  in_kind = '0;
  logic        in_tbl_dptr = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_next_pc, out_code_addr;
  logic        out_code_rd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pcnu_next_pc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_len(in_len), .in_opcode(in_opcode), .in_op1(in_op1),
    .in_op2(in_op2), .in_acc(in_acc), .in_dptr(in_dptr), .in_taken(in_taken),
    .in_kind(in_kind), .in_tbl_dptr(in_tbl_dptr), .out_valid(out_valid),
    .out_ready(out_ready), .out_next_pc(out_next_pc),
    .out_code_addr(out_code_addr), .out_code_rd(out_code_rd)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] pc, input logic [1:0] len, input logic [2:0] kind,
                     input logic [7:0] opc, input logic [7:0] o1, input logic [7:0] o2,
                     input logic tk, input logic [7:0] acc, input logic [15:0] dp, input logic sel);
    in_pc = pc; in_len = len; in_kind = kind; in_opcode = opc; in_op1 = o1; in_op2 = o2;
    in_taken = tk; in_acc = acc; in_dptr = dp; in_tbl_dptr = sel;
  endtask

  // One request, result read one edge later.
  task automatic send(input string req, input logic [15:0] pc, input logic [1:0] len,
                      input logic [2:0] kind, input logic [7:0] opc, input logic [7:0] o1,
                      input logic [7:0] o2, input logic tk, input logic [7:0] acc,
                      input logic [15:0] dp, input logic sel,
                      input logic [15:0] exp_pc, input logic [15:0] exp_ca, input logic exp_rd);
    @(negedge clk);
    put(pc, len, kind, opc, o1, o2, tk, acc, dp, sel);
    in_valid = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    chk(req, "out_valid", 32'(out_valid), 32'd1);
    chk(req, "out_next_pc", 32'(out_next_pc), 32'(exp_pc));
    chk(req, "out_code_addr", 32'(out_code_addr), 32'(exp_ca));
    chk(req, "out_code_rd", 32'(out_code_rd), 32'(exp_rd));
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    chk("R1", "in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1", "in_ready after reset", 32'(in_ready), 32'd1);
  endtask

  task automatic t_seq;
    send("R2", 16'h1000, 2'd1, 3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0, 1'b0, 16'h1001, 16'h0, 1'b0);
    send("R2", 16'h1000, 2'd3, 3'd0, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00, 16'h0, 1'b0, 16'h1003, 16'h0, 1'b0);
    send("R2", 16'hFFFF, 2'd2, 3'd0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00, 16'h0, 1'b0, 16'h0001, 16'h0, 1'b0);
    send("R2", 16'h4000, 2'd2, 3'd6, 8'hFF, 8'hFF, 8'hFF, 1'b1, 8'h00, 16'h0, 1'b0, 16'h4002, 16'h0, 1'b0);
  endtask

  task automatic t_rel;
    send("R3", 16'h0100, 2'd2, 3'd1, 8'h80, 8'h05, 8'h77, 1'b1, 8'h00, 16'h0, 1'b0, 16'h0107, 16'h0, 1'b0);
    send("R3", 16'h0100, 2'd2, 3'd1, 8'h80, 8'hFE, 8'h00, 1'b1, 8'h00, 16'h0, 1'b0, 16'h0100, 16'h0, 1'b0);
    send("R3", 16'h0100, 2'd3, 3'd1, 8'hB4, 8'h11, 8'h80, 1'b1, 8'h00, 16'h0, 1'b0, 16'h0083, 16'h0, 1'b0);
    send("R3", 16'hFFF0, 2'd2, 3'd1, 8'h80, 8'h20, 8'h00, 1'b1, 8'h00, 16'h0, 1'b0, 16'h0012, 16'h0, 1'b0);
    send("R4", 16'h0100, 2'd2, 3'd1, 8'h80, 8'h05, 8'h00, 1'b0, 8'h00, 16'h0, 1'b0, 16'h0102, 16'h0, 1'b0);
  endtask

  task automatic t_abs;
    // following address 0x3800 keeps page 00111; opcode 111, low byte 0x34
    send("R5", 16'h37FE, 2'd2, 3'd2, 8'hE1, 8'h34, 8'h99, 1'b0, 8'h00, 16'h0, 1'b0, 16'h3F34, 16'h0, 1'b0);
    send("R5", 16'h1234, 2'd2, 3'd2, 8'h11, 8'hFF, 8'h00, 1'b1, 8'h00, 16'h0, 1'b0, 16'h10FF, 16'h0, 1'b0);
  endtask

  task automatic t_long;
    send("R6", 16'h2222, 2'd3, 3'd3, 8'h02, 8'hAB, 8'hCD, 1'b0, 8'h00, 16'h0, 1'b0, 16'hABCD, 16'h0, 1'b0);
  endtask

  task automatic t_table;
    send("R7", 16'h0500, 2'd1, 3'd4, 8'h93, 8'h00, 8'h00, 1'b0, 8'hFF, 16'hFFF0, 1'b1, 16'h0501, 16'h00EF, 1'b1);
    send("R7", 16'h2000, 2'd1, 3'd4, 8'h83, 8'h00, 8'h00, 1'b0, 8'h10, 16'h8000, 1'b0, 16'h2001, 16'h2011, 1'b1);
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    put(16'h0010, 2'd3, 3'd3, 8'h02, 8'h12, 8'h34, 1'b0, 8'h00, 16'h0, 1'b0);
    in_valid = 1'b1;
    @(posedge clk); #1;
    put(16'h0020, 2'd3, 3'd3, 8'h02, 8'h56, 8'h78, 1'b0, 8'h00, 16'h0, 1'b0);
    @(negedge clk);
    chk("R8", "first result", 32'(out_next_pc), 32'h1234);
    chk("R9", "in_ready while stalled", 32'(in_ready), 32'd0);
    @(negedge clk);
    chk("R9", "held result", 32'(out_next_pc), 32'h1234);
    chk("R9", "held valid", 32'(out_valid), 32'd1);
    out_ready = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    chk("R8", "second result after release", 32'(out_next_pc), 32'h5678);
    chk("R8", "valid after release", 32'(out_valid), 32'd1);
    @(negedge clk);
    chk("R8", "drained", 32'(out_valid), 32'd0);
  endtask

  initial begin
    t_reset();
    t_seq();
    t_rel();
    t_abs();
    t_long();
    t_table();
    t_stall();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule